// File: doc/BRIEF.md
# Flash Word Program Poller

This block sits on the host side of a parallel NOR flash and performs one complete word program. A single request carries the target address, the data word, the way completion is to be detected, and a limit on poll reads. The block then drives a synchronous request/acknowledge bus. It issues the three-step unlock-and-program command prefix, writes the data word, and reads the target address back until the device status shows that the operation has finished or has failed.

Completion can be detected in two ways. In data polling, bit 7 of the read-back word is compared with bit 7 of the written data. In toggle polling, two reads are taken back to back and the block watches whether bit 6 flips between them. Bit 5 is the device's internal time-limit flag. It never causes a failure on its own: the block first takes confirming reads, because the completion bits may settle in the same cycle that bit 5 rises. On any failure the block writes the read-mode reset command before it reports the result.

Top module: `nor_prog_poller`

## Requirements
- R1: A request is taken only in a cycle where `req_ready` is high, and `req_ready` is high only while no operation is running. A `req_valid` asserted while busy has no effect on the bus sequence or the result.
- R2: After a request, the bus writes are issued in this order: 0xAA to address 0x555, 0x55 to address 0x2AA, 0xA0 to address 0x555, then the data word to the target address. All polling reads then use the target address.
- R3: Only one of `bus_wr` and `bus_rd` is high at a time. A strobe stays high with unchanged address and write data until the first cycle in which `bus_ack` is sampled high, and it is low in the following cycle.
- R4: In data-poll mode (`poll_mode`=0), a poll read whose bit 7 equals bit 7 of the written data gives a pass.
- R5: In data-poll mode, a read with a bit 7 mismatch and bit 5 set causes exactly one more read. A bit 7 match on that read gives a pass, and a mismatch gives a fail.
- R6: In toggle-poll mode (`poll_mode`=1), reads come in pairs. A pair with equal bit 6 gives a pass, and a pair with differing bit 6 and bit 5 clear starts another pair.
- R7: In toggle-poll mode, a pair with differing bit 6 and bit 5 set on the second read causes exactly two more reads. Equal bit 6 on those two reads gives a pass, and differing bit 6 gives a fail.
- R8: Poll reads (not the confirming reads) are counted. When an undecided poll result is seen and the count, including that read, has reached `poll_limit`, the operation fails. With limit 3 in data mode, exactly 3 reads are made; with limit 4 in toggle mode, exactly 4 reads are made.
- R9: Every fail is preceded by one bus write of 0x00F0 to address 0, issued after the last read. A pass issues no further bus cycle.
- R10: The result is shown by `res_valid` high for exactly one cycle, with `res_pass` giving the outcome. `req_ready` is high in that same cycle. After reset, `req_ready` is high and `res_valid`, `bus_wr` and `bus_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Program request |
| req_addr | input | AW | Target word address |
| req_data | input | DW | Word to program |
| req_mode | input | 1 | 0 = data polling, 1 = toggle polling |
| req_limit | input | LW | Maximum poll reads before timeout |
| req_ready | output | 1 | Idle; a request is accepted |
| res_valid | output | 1 | One-cycle result strobe |
| res_pass | output | 1 | Result: 1 pass, 0 fail |
| bus_wr | output | 1 | Write strobe, held until acknowledged |
| bus_rd | output | 1 | Read strobe, held until acknowledged |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_ack | input | 1 | Bus acknowledge, one cycle per transfer |
| bus_rdata | input | DW | Read data, valid with bus_ack |

## Verification
The hardest case to reach is the one where bit 5 rises in the same read that the completion bit settles. In that case the confirming read, or the confirming pair, decides the result, not the flag. The bench reaches it with a scripted flash responder that returns a queue of status words prepared for each test. It puts the bit 5 flag on exactly the read that should trigger confirmation, and then supplies either settled or still-changing words. The poll-limit path is reached by supplying words that never settle and never raise bit 5. The count of reads expected in the scoreboard then shows whether the block stopped at the right read.

// File: rtl/npp_pkg.sv
package npp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_POLL_A,
    ST_POLL_B,
    ST_CONF_A,
    ST_CONF_B,
    ST_ABORT
  } npp_state_e;

  typedef enum logic {
    MODE_DATA   = 1'b0,
    MODE_TOGGLE = 1'b1
  } npp_mode_e;

  localparam int unsigned CMD_STEPS = 4;

  localparam logic [11:0] UNLOCK_A = 12'h555;
  localparam logic [11:0] UNLOCK_B = 12'h2AA;
  localparam logic [7:0]  KEY_1    = 8'hAA;
  localparam logic [7:0]  KEY_2    = 8'h55;
  localparam logic [7:0]  KEY_PGM  = 8'hA0;
  localparam logic [7:0]  KEY_RST  = 8'hF0;

  localparam int unsigned BIT_DPOLL  = 7;
  localparam int unsigned BIT_TOGGLE = 6;
  localparam int unsigned BIT_TLIM   = 5;

endpackage

// File: rtl/npp_bus_port.sv
module npp_bus_port #(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_wr,
  input  logic          start_rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          bus_ack,
  output logic          bus_wr,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          active,
  output logic          xfer_done
);

  assign active    = bus_wr | bus_rd;
  assign xfer_done = active & bus_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_wr    <= 1'b0;
      bus_rd    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (xfer_done) begin
      bus_wr <= 1'b0;
      bus_rd <= 1'b0;
    end else if (!active) begin
      if (start_wr) begin
        bus_wr    <= 1'b1;
        bus_addr  <= addr;
        bus_wdata <= wdata;
      end else if (start_rd) begin
        bus_rd   <= 1'b1;
        bus_addr <= addr;
      end
    end
  end

endmodule

// File: rtl/npp_status_eval.sv
module npp_status_eval #(
  parameter int unsigned DW = 16
) (
  input  logic          mode,
  input  logic          want_b7,
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] prev,
  output logic          settled,
  output logic          tlim_flag
);
  import npp_pkg::*;

  logic data_match;
  logic toggle_still;

  assign data_match   = (cur[BIT_DPOLL] == want_b7);
  assign toggle_still = (cur[BIT_TOGGLE] == prev[BIT_TOGGLE]);

  always_comb begin
    if (mode == MODE_DATA) settled = data_match;
    else                   settled = toggle_still;
  end

  assign tlim_flag = cur[BIT_TLIM];

endmodule

// File: rtl/npp_poll_ctr.sv
module npp_poll_ctr #(
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [LW-1:0] limit,
  output logic          reached
);

  logic [LW-1:0] cnt;
  logic [LW:0]   cnt_next;

  assign cnt_next = {1'b0, cnt} + 1'b1;
  assign reached  = (cnt_next >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && !cnt_next[LW]) begin
      cnt <= cnt_next[LW-1:0];
    end
  end

endmodule

// File: rtl/nor_prog_poller.sv
module nor_prog_poller #(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16,
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_mode,
  input  logic [LW-1:0] req_limit,
  output logic          req_ready,
  output logic          res_valid,
  output logic          res_pass,
  output logic          bus_wr,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);
  import npp_pkg::*;

  localparam int unsigned SW = $clog2(CMD_STEPS);
  localparam logic [SW-1:0] LAST_STEP = SW'(CMD_STEPS - 1);

  npp_state_e    state;
  logic [SW-1:0] step;
  logic [AW-1:0] tgt_addr;
  logic [DW-1:0] tgt_data;
  logic          mode;
  logic [LW-1:0] limit;
  logic [DW-1:0] prev;

  logic          start_wr, start_rd;
  logic [AW-1:0] nxt_addr;
  logic [DW-1:0] nxt_wdata;
  logic          active, xfer_done;
  logic          settled, tlim_flag, reached;
  logic          accept, poll_read;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign poll_read = xfer_done && (state == ST_POLL_A || state == ST_POLL_B);

  // Address and data for the next transfer
  always_comb begin
    start_wr  = 1'b0;
    start_rd  = 1'b0;
    nxt_addr  = tgt_addr;
    nxt_wdata = '0;
    unique case (state)
      ST_CMD: begin
        start_wr = !active;
        unique case (step)
          2'd0: begin nxt_addr = AW'(UNLOCK_A); nxt_wdata = DW'(KEY_1);   end
          2'd1: begin nxt_addr = AW'(UNLOCK_B); nxt_wdata = DW'(KEY_2);   end
          2'd2: begin nxt_addr = AW'(UNLOCK_A); nxt_wdata = DW'(KEY_PGM); end
          default: begin nxt_addr = tgt_addr;  nxt_wdata = tgt_data;      end
        endcase
      end
      ST_ABORT: begin
        start_wr  = !active;
        nxt_addr  = '0;
        nxt_wdata = DW'(KEY_RST);
      end
      ST_POLL_A, ST_POLL_B, ST_CONF_A, ST_CONF_B: start_rd = !active;
      default: ;
    endcase
  end

  npp_bus_port #(.AW(AW), .DW(DW)) u_port (
    .clk       (clk),
    .rst       (rst),
    .start_wr  (start_wr),
    .start_rd  (start_rd),
    .addr      (nxt_addr),
    .wdata     (nxt_wdata),
    .bus_ack   (bus_ack),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .active    (active),
    .xfer_done (xfer_done)
  );

  npp_status_eval #(.DW(DW)) u_eval (
    .mode      (mode),
    .want_b7   (tgt_data[BIT_DPOLL]),
    .cur       (bus_rdata),
    .prev      (prev),
    .settled   (settled),
    .tlim_flag (tlim_flag)
  );

  npp_poll_ctr #(.LW(LW)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .clr     (accept),
    .inc     (poll_read),
    .limit   (limit),
    .reached (reached)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      step      <= '0;
      tgt_addr  <= '0;
      tgt_data  <= '0;
      mode      <= MODE_DATA;
      limit     <= '0;
      prev      <= '0;
      res_valid <= 1'b0;
      res_pass  <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          tgt_addr <= req_addr;
          tgt_data <= req_data;
          mode     <= req_mode;
          limit    <= req_limit;
          step     <= '0;
          state    <= ST_CMD;
        end
        ST_CMD: if (xfer_done) begin
          if (step == LAST_STEP) state <= ST_POLL_A;
          step <= step + 1'b1;
        end
        ST_POLL_A, ST_POLL_B: if (xfer_done) begin
          prev <= bus_rdata;
          if (state == ST_POLL_A && mode == MODE_TOGGLE) begin
            state <= ST_POLL_B;
          end else if (settled) begin
            res_valid <= 1'b1;
            res_pass  <= 1'b1;
            state     <= ST_IDLE;
          end else if (tlim_flag) begin
            state <= (mode == MODE_DATA) ? ST_CONF_B : ST_CONF_A;
          end else if (reached) begin
            state <= ST_ABORT;
          end else begin
            state <= ST_POLL_A;
          end
        end
        ST_CONF_A: if (xfer_done) begin
          prev  <= bus_rdata;
          state <= ST_CONF_B;
        end
        ST_CONF_B: if (xfer_done) begin
          if (settled) begin
            res_valid <= 1'b1;
            res_pass  <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            state <= ST_ABORT;
          end
        end
        ST_ABORT: if (xfer_done) begin
          res_valid <= 1'b1;
          res_pass  <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/npp_checker.sv
module npp_checker #(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          res_valid,
  input logic          res_pass,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ack
);

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));

  assert_wr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_ack) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_ack) |=> (bus_rd && $stable(bus_addr)));

  assert_release_R3: assert property (@(posedge clk) disable iff (rst)
    ((bus_wr || bus_rd) && bus_ack) |=> !(bus_wr || bus_rd));

  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr || bus_rd) |-> !req_ready);

  assert_res_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_res_ready_R10: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> req_ready);

  assert_fail_reset_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_pass) |-> $past(bus_wr && bus_ack && bus_wdata[7:0] == 8'hF0));

  assert_pass_read_R4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_pass) |-> $past(bus_rd && bus_ack));

endmodule

bind nor_prog_poller npp_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .res_valid (res_valid),
  .res_pass  (res_pass),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ack   (bus_ack)
);

// File: tb/sim_nor_prog_poller.sv
module sim_nor_prog_poller;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int LW = 8;
  localparam int XW = 1 + AW + DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_mode = 1'b0;
  logic [LW-1:0] req_limit = '0;
  logic req_ready, res_valid, res_pass, bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_ack = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  int checks = 0;
  int fails = 0;
  int results_seen = 0;
  int ack_delay = 0;
  int wcnt = 0;
  int cycles = 0;

  logic [XW-1:0] exp_q[$];
  string         exp_tag_q[$];
  logic          exp_res_q[$];
  string         res_tag_q[$];
  logic [DW-1:0] rd_q[$];

  always #5 clk = ~clk;

  nor_prog_poller #(.AW(AW), .DW(DW), .LW(LW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_mode(req_mode), .req_limit(req_limit),
    .req_ready(req_ready), .res_valid(res_valid), .res_pass(res_pass),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // Flash responder and transaction monitor
  always @(negedge clk) begin
    if (rst) begin
      bus_ack = 1'b0;
      wcnt = 0;
    end else if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_wr || bus_rd) begin
      if (wcnt >= ack_delay) begin
        logic [XW-1:0] e;
        string tg;
        wcnt = 0;
        bus_ack = 1'b1;
        check(!(bus_wr && bus_rd), "R3", "both strobes high");
        if (bus_rd) bus_rdata = (rd_q.size() > 0) ? rd_q.pop_front() : '0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", $sformatf("unexpected %s addr=%h data=%h",
                bus_wr ? "write" : "read", bus_addr, bus_wdata));
        end else begin
          e  = exp_q.pop_front();
          tg = exp_tag_q.pop_front();
          if (e[XW-1]) begin
            check(bus_rd && bus_addr == e[AW+DW-1:DW], tg,
                  $sformatf("got %s addr=%h, expected read addr=%h",
                  bus_wr ? "write" : "read", bus_addr, e[AW+DW-1:DW]));
          end else begin
            check(bus_wr && bus_addr == e[AW+DW-1:DW] && bus_wdata == e[DW-1:0], tg,
                  $sformatf("got %s addr=%h data=%h, expected write addr=%h data=%h",
                  bus_wr ? "write" : "read", bus_addr, bus_wdata,
                  e[AW+DW-1:DW], e[DW-1:0]));
          end
        end
      end else begin
        wcnt++;
      end
    end
  end

  // Result monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      logic er;
      string tg;
      if (exp_res_q.size() == 0) begin
        check(1'b0, "R10", "unexpected result");
      end else begin
        er = exp_res_q.pop_front();
        tg = res_tag_q.pop_front();
        check(res_pass == er, tg, $sformatf("res_pass=%0b expected=%0b", res_pass, er));
        check(exp_q.size() == 0, tg,
              $sformatf("%0d expected bus cycles missing, expected 0", exp_q.size()));
        check(req_ready == 1'b1, "R10", $sformatf("req_ready=%0b with result, expected 1", req_ready));
      end
      results_seen++;
    end
  end

  task automatic push_x(input bit rd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input string tag);
    exp_q.push_back({rd, a, d});
    exp_tag_q.push_back(tag);
  endtask

  task automatic run_prog(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit mode,
                          input int lim, input int nreads, input bit pass,
                          input string tag, input bit busy_poke);
    int target;
    push_x(1'b0, 20'h555, 16'h00AA, "R2");
    push_x(1'b0, 20'h2AA, 16'h0055, "R2");
    push_x(1'b0, 20'h555, 16'h00A0, "R2");
    push_x(1'b0, a, d, busy_poke ? "R1" : "R2");
    for (int i = 0; i < nreads; i++) push_x(1'b1, a, '0, tag);
    if (!pass) push_x(1'b0, '0, 16'h00F0, "R9");
    exp_res_q.push_back(pass);
    res_tag_q.push_back(tag);
    target = results_seen + 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_data  = d;
    req_mode  = mode;
    req_limit = LW'(lim);
    @(negedge clk);
    if (busy_poke) begin
      req_addr = 20'h0F0F0;
      req_data = 16'hBEEF;
      req_mode = ~mode;
      for (int i = 0; i < 6; i++) begin
        check(req_ready == 1'b0, "R1", $sformatf("req_ready=%0b while busy, expected 0", req_ready));
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    wait (results_seen >= target);
    @(negedge clk);
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    check(1'b0, "R10", "watchdog expired, run hung");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R10", $sformatf("reset req_ready=%0b expected 1", req_ready));
    check(res_valid == 1'b0, "R10", $sformatf("reset res_valid=%0b expected 0", res_valid));
    check(!bus_wr && !bus_rd, "R10", $sformatf("reset strobes wr=%0b rd=%0b expected 0", bus_wr, bus_rd));

    // R4: data poll, immediate match (data bit7=0)
    ack_delay = 0;
    rd_q.push_back(16'h0034);
    run_prog(20'h01234, 16'h1234, 1'b0, 16, 1, 1'b1, "R4", 1'b0);

    // R4 / R1: busy then match, with request poked while busy
    ack_delay = 1;
    rd_q.push_back(16'h0080); rd_q.push_back(16'h0080); rd_q.push_back(16'h0000);
    run_prog(20'h00100, 16'h1234, 1'b0, 16, 3, 1'b1, "R4", 1'b1);

    // R5: bit5 with mismatch, confirm read matches (data bit7=1)
    ack_delay = 2;
    rd_q.push_back(16'h0020); rd_q.push_back(16'h0080);
    run_prog(20'h7FFFF, 16'h00C5, 1'b0, 16, 2, 1'b1, "R5", 1'b0);

    // R5: bit5 with mismatch, confirm still mismatches -> fail
    ack_delay = 0;
    rd_q.push_back(16'h00A0); rd_q.push_back(16'h00A0);
    run_prog(20'h00200, 16'h1234, 1'b0, 16, 2, 1'b0, "R5", 1'b0);

    // R8: data poll timeout after 3 reads
    rd_q.push_back(16'h0080); rd_q.push_back(16'h0080); rd_q.push_back(16'h0080);
    run_prog(20'h00300, 16'h1234, 1'b0, 3, 3, 1'b0, "R8", 1'b0);

    // R6: toggle, first pair steady
    ack_delay = 1;
    rd_q.push_back(16'h0044); rd_q.push_back(16'h0044);
    run_prog(20'h00400, 16'h5A5A, 1'b1, 16, 2, 1'b1, "R6", 1'b0);

    // R6: toggle, one toggling pair then steady pair
    rd_q.push_back(16'h0000); rd_q.push_back(16'h0040);
    rd_q.push_back(16'h0040); rd_q.push_back(16'h0040);
    run_prog(20'h00500, 16'h5A5A, 1'b1, 16, 4, 1'b1, "R6", 1'b0);

    // R7: toggle with bit5, confirm pair steady -> pass
    ack_delay = 0;
    rd_q.push_back(16'h0000); rd_q.push_back(16'h0060);
    rd_q.push_back(16'h0000); rd_q.push_back(16'h0000);
    run_prog(20'h00600, 16'h5A5A, 1'b1, 16, 4, 1'b1, "R7", 1'b0);

    // R7: toggle with bit5, confirm pair still toggling -> fail
    rd_q.push_back(16'h0000); rd_q.push_back(16'h0060);
    rd_q.push_back(16'h0020); rd_q.push_back(16'h0060);
    run_prog(20'h00700, 16'h5A5A, 1'b1, 16, 4, 1'b0, "R7", 1'b0);

    // R8: toggle timeout after 4 reads
    ack_delay = 2;
    rd_q.push_back(16'h0040); rd_q.push_back(16'h0000);
    rd_q.push_back(16'h0040); rd_q.push_back(16'h0000);
    run_prog(20'h00800, 16'h5A5A, 1'b1, 4, 4, 1'b0, "R8", 1'b0);

    repeat (5) @(negedge clk);
    check(exp_res_q.size() == 0 && exp_q.size() == 0, "R10",
          $sformatf("leftover results=%0d cycles=%0d expected 0", exp_res_q.size(), exp_q.size()));
    check(!bus_wr && !bus_rd && req_ready, "R9", "bus not idle after final fail");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule